// File: doc/BRIEF.md
# Power-Down Mode Controller

This block steps a processor through its low-power states: run, sleep, software standby and hardware standby. It also holds a power-on reset state. A sleep-instruction strobe is the trigger. A standby-select bit decides whether the strobe leads to light sleep, where only the CPU clock stops, or to deep standby, where every clock and the external clock output stop.

Each low-power state has its own set of exit events. Sleep ends on an enabled interrupt whose priority is strictly above the current mask level, or on a DMA address error. Software standby ends only on a non-maskable wake input, and only after an oscillator-settle count has run out. The reset input and the hardware-standby input take precedence over everything else.

While in standby the controller puts the external bus into high impedance. It ignores bus-release requests and holds the acknowledge inactive. It also tracks the settling delay of writes to the standby-select bit, so a strobe that arrives too soon after a write still sees the old value.

Top module: `pdm_ctrl`

## Requirements
- R1: While `rst` is high or `por_n` is low, the block is in the power-on reset state with all three clock enables low, `bus_hiz` high, `back_n` high and `wake_cause` 0. The first clock edge with `rst` low and `por_n` high moves it to run, where all three clock enables are high.
- R2: A `sleep_req` sampled in run while the effective standby bit is 0 enters sleep: `cpu_clk_en` goes low while `per_clk_en` and `ckout_en` stay high.
- R3: In sleep, `irq_valid` with `irq_en` high and `irq_prio` strictly greater than `mask_lvl` returns the block to run with `wake_cause` 1. A request with priority equal to or below the mask, or with `irq_en` low, leaves it in sleep.
- R4: In sleep, `dma_aerr` returns the block to run with `wake_cause` 2. It takes precedence over an interrupt wake in the same cycle.
- R5: `hstby_n` low in any state other than power-on reset enters hardware standby: all clock enables low, `bus_hiz` high, `back_n` high. The block stays there after `hstby_n` returns high, until `por_n` or `rst` resets it.
- R6: A `sleep_req` sampled in run while the effective standby bit is 1 enters software standby, with `cpu_clk_en`, `per_clk_en` and `ckout_en` all low.
- R7: `per_prst` is high for exactly one cycle, the first cycle of software standby. It is low at all other times.
- R8: In software standby `bus_hiz` is high and `back_n` is high, whatever `breq_n` does. This holds even when the bus was released before entry.
- R9: A standby-bit write (`sby_wr` with `sby_wdata`) sampled at one edge governs sleep strobes sampled `SBY_DLY`+1 or more edges later. Strobes sampled earlier use the previous bit value.
- R10: In software standby, interrupts and address errors have no effect. `nmi_wake` starts a settle phase of `OSC_CNT` cycles with all clocks still off. The block then enters run with `wake_cause` 3.
- R11: In run and sleep, `back_n` follows `breq_n` one edge later and `bus_hiz` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_n | input | 1 | Power-on reset request, active low |
| hstby_n | input | 1 | Hardware standby request, active low |
| sleep_req | input | 1 | Sleep-instruction strobe |
| sby_wr | input | 1 | Write strobe for the standby-select bit |
| sby_wdata | input | 1 | New standby-select value (1 = software standby) |
| irq_valid | input | 1 | Interrupt request present |
| irq_en | input | 1 | Interrupt enabled at its source |
| irq_prio | input | PRIO_W | Interrupt priority |
| mask_lvl | input | PRIO_W | Current interrupt mask level |
| dma_aerr | input | 1 | DMA address-error event |
| nmi_wake | input | 1 | Non-maskable wake from software standby |
| breq_n | input | 1 | Bus-release request, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| ckout_en | output | 1 | External clock-output enable |
| per_prst | output | 1 | Peripheral partial-reset pulse |
| bus_hiz | output | 1 | External bus high-impedance enable |
| back_n | output | 1 | Bus-release acknowledge, active low |
| wake_cause | output | 2 | Last wake cause: 0 reset, 1 interrupt, 2 address error, 3 non-maskable |

## Verification
Sleep exit is driven with a set of interrupt and address-error patterns. Priorities just above, equal to and below the mask, including the top value 15 against masks of 14 and 15, show that the compare is strict. A high-priority request with its source disabled shows that the enable gates the wake, and a request that coincides with an address error shows which cause code wins. In standby, the standby-bit write is probed one edge inside and one edge outside its settle window. A bus that was already released is carried into standby to show that the acknowledge is forced inactive, and the settle phase is timed to its last cycle.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_RUN    = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_SSTBY  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_HSTBY  = 3'd5
  } pdm_state_e;

  typedef enum logic [1:0] {
    WC_RESET = 2'd0,
    WC_IRQ   = 2'd1,
    WC_AERR  = 2'd2,
    WC_NMI   = 2'd3
  } wake_cause_e;
endpackage

// File: rtl/pdm_sby_sync.sv
// Delays a standby-select write by DLY edges before it becomes effective.
module pdm_sby_sync #(
  parameter int DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  output logic eff
);
  logic [DLY-1:0] vld_q;
  logic [DLY-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= 1'b0;
      dat_q[0] <= 1'b0;
    end else begin
      vld_q[0] <= wr;
      dat_q[0] <= wdata;
    end
  end

  for (genvar i = 1; i < DLY; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[i] <= 1'b0;
        dat_q[i] <= 1'b0;
      end else begin
        vld_q[i] <= vld_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) eff <= 1'b0;
    else if (vld_q[DLY-1]) eff <= dat_q[DLY-1];
  end

  // R9: a write never changes the effective bit at the next edge
  a_r9_no_early_effect: assert property (@(posedge clk) disable iff (rst)
    wr |=> eff == $past(eff));
endmodule

// File: rtl/pdm_wake_eval.sv
// Classifies wake events that may end sleep.
module pdm_wake_eval #(
  parameter int PRIO_W = 4
) (
  input  logic              irq_valid,
  input  logic              irq_en,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] mask_lvl,
  input  logic              dma_aerr,
  output logic              irq_wake,
  output logic              aerr_wake
);
  always_comb begin
    irq_wake  = irq_valid && irq_en && (irq_prio > mask_lvl);
    aerr_wake = dma_aerr;
  end
endmodule

// File: rtl/pdm_osc_timer.sv
// Oscillator settle counter: loads on start, expires OSC_CNT edges later.
module pdm_osc_timer #(
  parameter int OSC_CNT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(OSC_CNT + 1);
  localparam logic [CW-1:0] LOAD = CW'(OSC_CNT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb expired = (cnt_q == '0);

  // R10: counter only moves downward while running
  a_r10_count_down: assert property (@(posedge clk) disable iff (rst)
    (!start && $past(cnt_q) != '0 && !$past(rst)) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
#(
  parameter int PRIO_W  = 4,
  parameter int SBY_DLY = 3,
  parameter int OSC_CNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_n,
  input  logic              hstby_n,
  input  logic              sleep_req,
  input  logic              sby_wr,
  input  logic              sby_wdata,
  input  logic              irq_valid,
  input  logic              irq_en,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] mask_lvl,
  input  logic              dma_aerr,
  input  logic              nmi_wake,
  input  logic              breq_n,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              ckout_en,
  output logic              per_prst,
  output logic              bus_hiz,
  output logic              back_n,
  output logic [1:0]        wake_cause
);
  pdm_state_e  st_q, st_d;
  wake_cause_e cause_d;
  logic        sby_eff, irq_wake, aerr_wake, osc_done, osc_start, prst_d;

  pdm_sby_sync #(.DLY(SBY_DLY)) u_sby (
    .clk(clk), .rst(rst), .wr(sby_wr), .wdata(sby_wdata), .eff(sby_eff)
  );

  pdm_wake_eval #(.PRIO_W(PRIO_W)) u_wake (
    .irq_valid(irq_valid), .irq_en(irq_en), .irq_prio(irq_prio),
    .mask_lvl(mask_lvl), .dma_aerr(dma_aerr),
    .irq_wake(irq_wake), .aerr_wake(aerr_wake)
  );

  pdm_osc_timer #(.OSC_CNT(OSC_CNT)) u_osc (
    .clk(clk), .rst(rst), .start(osc_start), .expired(osc_done)
  );

  always_comb begin
    st_d    = st_q;
    cause_d = wake_cause_e'(wake_cause);
    prst_d  = 1'b0;
    if (!por_n) begin
      st_d    = ST_POR;
      cause_d = WC_RESET;
    end else if (!hstby_n && st_q != ST_POR) begin
      st_d = ST_HSTBY;
    end else begin
      case (st_q)
        ST_POR:   st_d = ST_RUN;
        ST_RUN: begin
          if (sleep_req) begin
            if (sby_eff) begin
              st_d   = ST_SSTBY;
              prst_d = 1'b1;
            end else begin
              st_d = ST_SLEEP;
            end
          end
        end
        ST_SLEEP: begin
          if (aerr_wake) begin
            st_d    = ST_RUN;
            cause_d = WC_AERR;
          end else if (irq_wake) begin
            st_d    = ST_RUN;
            cause_d = WC_IRQ;
          end
        end
        ST_SSTBY:  if (nmi_wake) st_d = ST_SETTLE;
        ST_SETTLE: begin
          if (osc_done) begin
            st_d    = ST_RUN;
            cause_d = WC_NMI;
          end
        end
        ST_HSTBY:  st_d = ST_HSTBY;
        default:   st_d = ST_POR;
      endcase
    end
  end

  always_comb osc_start = (st_q == ST_SSTBY) && (st_d == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_POR;
      wake_cause <= WC_RESET;
      per_prst   <= 1'b0;
      cpu_clk_en <= 1'b0;
      per_clk_en <= 1'b0;
      ckout_en   <= 1'b0;
      bus_hiz    <= 1'b1;
      back_n     <= 1'b1;
    end else begin
      st_q       <= st_d;
      wake_cause <= cause_d;
      per_prst   <= prst_d;
      case (st_d)
        ST_RUN: begin
          cpu_clk_en <= 1'b1;
          per_clk_en <= 1'b1;
          ckout_en   <= 1'b1;
          bus_hiz    <= !breq_n;
          back_n     <= breq_n;
        end
        ST_SLEEP: begin
          cpu_clk_en <= 1'b0;
          per_clk_en <= 1'b1;
          ckout_en   <= 1'b1;
          bus_hiz    <= !breq_n;
          back_n     <= breq_n;
        end
        default: begin
          cpu_clk_en <= 1'b0;
          per_clk_en <= 1'b0;
          ckout_en   <= 1'b0;
          bus_hiz    <= 1'b1;
          back_n     <= 1'b1;
        end
      endcase
    end
  end

  // R1: reset input always lands in the reset state
  a_r1_por_entry: assert property (@(posedge clk) disable iff (rst)
    !por_n |=> (st_q == ST_POR && wake_cause == 2'd0));
  // R3: a request at or below the mask never wakes sleep
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLEEP && por_n && hstby_n && !dma_aerr && irq_prio <= mask_lvl)
      |=> !cpu_clk_en);
  // R5: hardware standby is left only through reset
  a_r5_hstby_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HSTBY && por_n) |=> (st_q == ST_HSTBY && !per_clk_en));
  // R6: every clock is off in software standby
  a_r6_clocks_off: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SSTBY || st_q == ST_SETTLE) |-> (!cpu_clk_en && !per_clk_en && !ckout_en));
  // R7: partial reset is a single-cycle pulse at standby entry
  a_r7_prst_pulse: assert property (@(posedge clk) disable iff (rst)
    per_prst |-> (st_q == ST_SSTBY && $past(st_q) == ST_RUN));
  a_r7_prst_single: assert property (@(posedge clk) disable iff (rst)
    per_prst |=> !per_prst);
  // R8: bus parked and acknowledge inactive in standby
  a_r8_bus_parked: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SSTBY) |-> (bus_hiz && back_n));
endmodule

// File: tb/pdm_ctrl_test.sv
module pdm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 3;
  localparam int OSC = 8;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst, por_n, hstby_n, sleep_req, sby_wr, sby_wdata;
  logic irq_valid, irq_en, dma_aerr, nmi_wake, breq_n;
  logic [3:0] irq_prio, mask_lvl;
  logic cpu_clk_en, per_clk_en, ckout_en, per_prst, bus_hiz, back_n;
  logic [1:0] wake_cause;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_ctrl #(.PRIO_W(4), .SBY_DLY(DLY), .OSC_CNT(OSC)) uut (
    .clk(clk), .rst(rst), .por_n(por_n), .hstby_n(hstby_n),
    .sleep_req(sleep_req), .sby_wr(sby_wr), .sby_wdata(sby_wdata),
    .irq_valid(irq_valid), .irq_en(irq_en), .irq_prio(irq_prio),
    .mask_lvl(mask_lvl), .dma_aerr(dma_aerr), .nmi_wake(nmi_wake),
    .breq_n(breq_n), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .ckout_en(ckout_en), .per_prst(per_prst), .bus_hiz(bus_hiz),
    .back_n(back_n), .wake_cause(wake_cause)
  );

  typedef struct packed {
    logic       en;
    logic       aerr;
    logic [3:0] prio;
    logic [3:0] mask;
    logic       wake;
    logic [1:0] cause;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 4'd5,  4'd3,  1'b1, 2'd1},
    '{1'b1, 1'b0, 4'd3,  4'd3,  1'b0, 2'd0},
    '{1'b1, 1'b0, 4'd2,  4'd3,  1'b0, 2'd0},
    '{1'b0, 1'b0, 4'd9,  4'd3,  1'b0, 2'd0},
    '{1'b0, 1'b1, 4'd0,  4'd0,  1'b1, 2'd2},
    '{1'b1, 1'b1, 4'd9,  4'd3,  1'b1, 2'd2},
    '{1'b1, 1'b0, 4'd15, 4'd14, 1'b1, 2'd1},
    '{1'b1, 1'b0, 4'd15, 4'd15, 1'b0, 2'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic aerr_out();
    dma_aerr = 1'b1; tick(); dma_aerr = 1'b0;
  endtask

  task automatic nmi_out();
    nmi_wake = 1'b1; tick(); nmi_wake = 1'b0;
    repeat (OSC) tick();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] last_cause;
    rst = 1'b1; por_n = 1'b1; hstby_n = 1'b1; sleep_req = 1'b0;
    sby_wr = 1'b0; sby_wdata = 1'b0; irq_valid = 1'b0; irq_en = 1'b0;
    irq_prio = '0; mask_lvl = '0; dma_aerr = 1'b0; nmi_wake = 1'b0; breq_n = 1'b1;
    @(negedge clk); tick(); tick();
    // R1 reset state
    chk("R1 cpu", cpu_clk_en, 0); chk("R1 ckout", ckout_en, 0);
    chk("R1 hiz", bus_hiz, 1); chk("R1 back", back_n, 1); chk("R1 cause", wake_cause, 0);
    rst = 1'b0; tick();
    chk("R1 run", {cpu_clk_en, per_clk_en, ckout_en}, 3'b111);

    // R11 bus release in run
    breq_n = 1'b0; tick();
    chk("R11 back low", back_n, 0); chk("R11 hiz", bus_hiz, 1);
    breq_n = 1'b1; tick();
    chk("R11 back high", back_n, 1); chk("R11 hiz off", bus_hiz, 0);

    // R2 R3 R4 vector walk
    last_cause = wake_cause;
    irq_valid = 1'b1;
    foreach (VECS[i]) begin
      sleep_req = 1'b1; tick(); sleep_req = 1'b0;
      chk("R2 sleep", {cpu_clk_en, per_clk_en, ckout_en}, 3'b011);
      irq_en = VECS[i].en; dma_aerr = VECS[i].aerr;
      irq_prio = VECS[i].prio; mask_lvl = VECS[i].mask;
      tick();
      irq_en = 1'b0; dma_aerr = 1'b0;
      chk("R3/R4 wake", cpu_clk_en, VECS[i].wake);
      if (VECS[i].wake) begin
        chk("R3/R4 cause", wake_cause, VECS[i].cause);
      end else begin
        chk("R3 cause kept", wake_cause, last_cause);
        aerr_out();
        chk("R4 aerr wake", {cpu_clk_en, wake_cause}, 3'b110);
      end
      last_cause = wake_cause;
    end
    irq_valid = 1'b0;

    // R9 strobe inside the write window uses old value (0 -> sleep)
    sby_wr = 1'b1; sby_wdata = 1'b1; tick(); sby_wr = 1'b0;
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R9 old value", {cpu_clk_en, per_clk_en}, 2'b01);
    aerr_out();

    // R6 R7 R8 software standby entered while bus released
    breq_n = 1'b0; tick();
    chk("R11 released", back_n, 0);
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R6 clocks off", {cpu_clk_en, per_clk_en, ckout_en}, 3'b000);
    chk("R7 pulse", per_prst, 1);
    chk("R8 back forced", back_n, 1); chk("R8 hiz", bus_hiz, 1);
    irq_valid = 1'b1; irq_en = 1'b1; irq_prio = 4'd15; mask_lvl = 4'd0; dma_aerr = 1'b1;
    tick();
    irq_valid = 1'b0; irq_en = 1'b0; dma_aerr = 1'b0;
    chk("R7 pulse ends", per_prst, 0);
    chk("R8 breq ignored", back_n, 1);
    chk("R10 irq/aerr ignored", {cpu_clk_en, per_clk_en}, 2'b00);
    breq_n = 1'b1;

    // R10 settle timing
    nmi_wake = 1'b1; tick(); nmi_wake = 1'b0;
    repeat (OSC - 1) tick();
    chk("R10 still settling", {cpu_clk_en, ckout_en}, 2'b00);
    tick();
    chk("R10 run", {cpu_clk_en, per_clk_en, ckout_en}, 3'b111);
    chk("R10 cause", wake_cause, 3);

    // R9 boundary: strobe DLY edges after write still uses old value (1)
    sby_wr = 1'b1; sby_wdata = 1'b0; tick(); sby_wr = 1'b0;
    repeat (DLY - 1) tick();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R9 boundary old", per_clk_en, 0);
    nmi_out();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
    chk("R9 new value", {cpu_clk_en, per_clk_en}, 2'b01);
    aerr_out();

    // R5 hardware standby
    breq_n = 1'b0; tick();
    hstby_n = 1'b0; tick();
    chk("R5 enter", {cpu_clk_en, per_clk_en, ckout_en, bus_hiz, back_n}, 5'b00011);
    hstby_n = 1'b1; breq_n = 1'b1; tick(); tick();
    chk("R5 sticky", {cpu_clk_en, per_clk_en}, 2'b00);

    // R1 reset input leaves hardware standby
    por_n = 1'b0; tick();
    chk("R1 por state", {cpu_clk_en, bus_hiz, back_n, wake_cause}, 5'b01100);
    por_n = 1'b1; tick();
    chk("R1 por release", {cpu_clk_en, per_clk_en, ckout_en}, 3'b111);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule